// File: doc/BRIEF.md
# Dual Register-Bank SPI Front End

This block is the register-facing half of a serial peripheral controller that serves two chip selects over one physical bus. It presents two identical register groups on a simple 32-bit word-addressed register bus. Each group holds its own configuration word, control word and data byte, and each group owns one chip-select pin. Both groups feed a single external byte shift engine, so the serial clock and both data lines are shared and only one byte transfer runs at a time.

Software sets a group's chip-select level and configuration, then writes a start bit into that group's control word. The front end holds the request pending until the shared engine is free. A fixed-priority arbiter picks the winning group, and the winner's direction, transmit byte and configuration are handed to the engine on a single-cycle launch pulse. When the engine signals completion, the owning group's busy flag drops and, for a read, the received byte lands in that group's data register. A global enable in a separate arbiter register decides whether the second group may launch transfers at all.

Top module: `dspi_regfront`

## Requirements
- R1: The bus is word addressed, and a read returns its data on `reg_rdata` from the clock edge that samples `reg_rd`. Group 0 occupies word addresses 0x00-0x0F and group 1 occupies 0x10-0x1F. Within a group, word 0 is status, word 4 is configuration, word 5 is control and word 8 is data. Word 0x3C is the arbiter register, with its enable in bit 31.
- R2: After reset, configuration, data, status and the arbiter enable read 0, each control word reads 0x1, and both `spi_cs_n` pins are high.
- R3: Status bit 0 of a group reads 1 from the edge that accepts that group's start until the edge that sees the engine's completion for that group's transfer.
- R4: Control bit 0 of a group sets that group's `spi_cs_n` pin level one cycle after the write, without touching the other pin. No other event changes the pin.
- R5: Control bit 2 requests a byte write. The engine launch shows `eng_write`=1, the group's data byte on `eng_tx_byte` and the group's configuration on `eng_cfg`. The data register keeps its value.
- R6: Control bit 1 requests a byte read, launched with `eng_write`=0. On completion `eng_rx_byte` is stored in the group's data register, which reads back zero-extended. Data bits above 7 are never stored.
- R7: A requested start reads back in control bits 2:1 while it is pending and clears once the engine accepts it. If bits 2 and 1 are written together, the write direction is used.
- R8: A start written while the engine is busy stays pending and launches only after the running transfer completes.
- R9: When both groups are pending while the engine is free, group 0 launches first and group 1 launches after it.
- R10: While the arbiter enable is 0, group 1 requests stay pending and never launch. Setting the enable lets them launch.
- R11: Only one launch occurs per transfer. No launch pulse occurs while a transfer is running.
- R12: Words other than the four group words and the arbiter word read 0, and writes to them change no register, pin or engine output.
- R13: The configuration register stores its low CFG_W bits (9 by default), and the bits above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_word_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| spi_cs_n | output | 2 | Chip-select pin per group |
| eng_start | output | 1 | One-cycle launch pulse to the shift engine |
| eng_write | output | 1 | Direction of the launched byte (1 = write) |
| eng_tx_byte | output | 8 | Byte to transmit |
| eng_cfg | output | 9 | Configuration of the owning group |
| eng_done | input | 1 | Engine completion pulse |
| eng_rx_byte | input | 8 | Received byte, valid with `eng_done` |

## Verification
The hardest state to reach is both groups pending at once, because a single register bus can only write one control word per cycle. The bench gets there by stretching the modelled engine latency and starting a group 1 write. While that transfer runs, it queues a group 1 read and then a group 0 write. It then reads the launch order back from the recorded engine configurations, which differ per group. The disabled-arbiter hold is reached the same way: a group 1 start is left waiting for many cycles before the enable is written.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int NGRP   = 2;
  localparam int OWN_W  = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int WIDX_W = 4;

  localparam logic [WIDX_W-1:0] OFF_STAT = 4'h0;
  localparam logic [WIDX_W-1:0] OFF_CFG  = 4'h4;
  localparam logic [WIDX_W-1:0] OFF_CTL  = 4'h5;
  localparam logic [WIDX_W-1:0] OFF_DATA = 4'h8;

  localparam logic [5:0] ARB_WIDX = 6'h3C;

  localparam int CTL_CS = 0;
  localparam int CTL_RD = 1;
  localparam int CTL_WR = 2;
endpackage

// File: rtl/dspi_bank.sv
module dspi_bank
  import dspi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_W  = 9,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] off,
  input  logic [CFG_W-1:0]  wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              grant_i,
  input  logic              owned_i,
  input  logic              rx_load_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              req_o,
  output logic              req_write_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [BYTE_W-1:0] tx_o,
  output logic              cs_o
);
  logic              pend_q;
  logic              pwr_q;
  logic              cs_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [BYTE_W-1:0] data_q;
  logic              wr_ctl;
  logic              wr_any_start;

  assign wr_ctl       = wr_en && (off == OFF_CTL);
  assign wr_any_start = wdata[CTL_WR] | wdata[CTL_RD];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      pwr_q  <= 1'b0;
      cs_q   <= 1'b1;
      cfg_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_en && (off == OFF_CFG)) cfg_q <= wdata;
      if (rx_load_i) data_q <= rx_byte_i;
      else if (wr_en && (off == OFF_DATA)) data_q <= wdata[BYTE_W-1:0];
      if (wr_ctl) cs_q <= wdata[CTL_CS];
      if (grant_i) begin
        pend_q <= 1'b0;
      end else if (wr_ctl && !pend_q && wr_any_start) begin
        pend_q <= 1'b1;
        pwr_q  <= wdata[CTL_WR];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_STAT: rdata = {{(DATA_W-1){1'b0}}, pend_q | owned_i};
      OFF_CFG:  rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
      OFF_CTL:  rdata = {{(DATA_W-3){1'b0}}, pend_q & pwr_q, pend_q & ~pwr_q, cs_q};
      OFF_DATA: rdata = {{(DATA_W-BYTE_W){1'b0}}, data_q};
      default:  rdata = '0;
    endcase
  end

  assign req_o       = pend_q;
  assign req_write_o = pwr_q;
  assign cfg_o       = cfg_q;
  assign tx_o        = data_q;
  assign cs_o        = cs_q;

  // R7: an accepted start is gone on the next cycle
  a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
    grant_i |=> !pend_q);
  // R4: the pin moves only on a control write
  a_r4_cs_only_ctl: assert property (@(posedge clk) disable iff (rst)
    !wr_ctl |=> $stable(cs_q));
  // R6: a completed read lands in the data register
  a_r6_rx_lands: assert property (@(posedge clk) disable iff (rst)
    rx_load_i |=> (data_q == $past(rx_byte_i)));
endmodule

// File: rtl/dspi_arb.sv
module dspi_arb
  import dspi_pkg::*;
#(
  parameter int CFG_W  = 9,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         arb_en,
  input  logic [NGRP-1:0]              req,
  input  logic [NGRP-1:0]              req_write,
  input  logic [NGRP-1:0][CFG_W-1:0]   cfg_in,
  input  logic [NGRP-1:0][BYTE_W-1:0]  tx_in,
  input  logic                         eng_done,
  output logic [NGRP-1:0]              grant,
  output logic [NGRP-1:0]              owned,
  output logic [NGRP-1:0]              rx_load,
  output logic                         eng_start,
  output logic                         eng_write,
  output logic [BYTE_W-1:0]            eng_tx,
  output logic [CFG_W-1:0]             eng_cfg
);
  logic             active_q;
  logic             start_q;
  logic             dir_q;
  logic [OWN_W-1:0] owner_q;
  logic [BYTE_W-1:0] tx_q;
  logic [CFG_W-1:0] cfg_q;
  logic [OWN_W-1:0] win;
  logic             found;

  always_comb begin
    grant = '0;
    win   = '0;
    found = 1'b0;
    if (!active_q) begin
      for (int g = 0; g < NGRP; g++) begin
        if (!found && req[g] && ((g == 0) || arb_en)) begin
          grant[g] = 1'b1;
          win      = OWN_W'(g);
          found    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      owner_q  <= '0;
      tx_q     <= '0;
      cfg_q    <= '0;
    end else begin
      start_q <= found;
      if (found) begin
        active_q <= 1'b1;
        owner_q  <= win;
        dir_q    <= req_write[win];
        tx_q     <= tx_in[win];
        cfg_q    <= cfg_in[win];
      end else if (eng_done) begin
        active_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_route
    assign owned[g]   = active_q && (owner_q == OWN_W'(g));
    assign rx_load[g] = eng_done && owned[g] && !dir_q;
  end

  assign eng_start = start_q;
  assign eng_write = dir_q;
  assign eng_tx    = tx_q;
  assign eng_cfg   = cfg_q;

  // R11: no launch while a transfer is still running
  a_r11_one_at_a_time: assert property (@(posedge clk) disable iff (rst)
    (active_q && !eng_done) |=> !start_q);
  // R10: a group other than 0 launches only with the enable set
  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    (start_q && (owner_q != '0)) |-> $past(arb_en));
  // R9: group 0 wins whenever it asks while the engine is free
  a_r9_low_first: assert property (@(posedge clk) disable iff (rst)
    (req[0] && !active_q) |=> (start_q && (owner_q == '0)));
endmodule

// File: rtl/dspi_regfront.sv
module dspi_regfront
  import dspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 9,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_word_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NGRP-1:0]   spi_cs_n,
  output logic              eng_start,
  output logic              eng_write,
  output logic [BYTE_W-1:0] eng_tx_byte,
  output logic [CFG_W-1:0]  eng_cfg,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_rx_byte
);
  localparam int REG_W = ADDR_W - WIDX_W;

  logic [REG_W-1:0]            region;
  logic [WIDX_W-1:0]           off;
  logic                        arb_hit;
  logic                        arb_en_q;
  logic [DATA_W-1:0]           rdata_nxt;
  logic [NGRP-1:0][DATA_W-1:0] bank_rdata;
  logic [NGRP-1:0]             bank_wr;
  logic [NGRP-1:0]             req;
  logic [NGRP-1:0]             req_write;
  logic [NGRP-1:0][CFG_W-1:0]  cfg_v;
  logic [NGRP-1:0][BYTE_W-1:0] tx_v;
  logic [NGRP-1:0]             grant;
  logic [NGRP-1:0]             owned;
  logic [NGRP-1:0]             rx_load;
  logic                        unused_wdata;

  assign region       = reg_word_addr[ADDR_W-1:WIDX_W];
  assign off          = reg_word_addr[WIDX_W-1:0];
  assign arb_hit      = (reg_word_addr == ADDR_W'(ARB_WIDX));
  assign unused_wdata = ^reg_wdata[DATA_W-2:CFG_W];

  for (genvar g = 0; g < NGRP; g++) begin : g_bank
    assign bank_wr[g] = reg_wr && (region == REG_W'(g));
    dspi_bank #(.DATA_W(DATA_W), .CFG_W(CFG_W), .BYTE_W(BYTE_W)) u_bank (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (bank_wr[g]),
      .off         (off),
      .wdata       (reg_wdata[CFG_W-1:0]),
      .rdata       (bank_rdata[g]),
      .grant_i     (grant[g]),
      .owned_i     (owned[g]),
      .rx_load_i   (rx_load[g]),
      .rx_byte_i   (eng_rx_byte),
      .req_o       (req[g]),
      .req_write_o (req_write[g]),
      .cfg_o       (cfg_v[g]),
      .tx_o        (tx_v[g]),
      .cs_o        (spi_cs_n[g])
    );
  end

  dspi_arb #(.CFG_W(CFG_W), .BYTE_W(BYTE_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .arb_en    (arb_en_q),
    .req       (req),
    .req_write (req_write),
    .cfg_in    (cfg_v),
    .tx_in     (tx_v),
    .eng_done  (eng_done),
    .grant     (grant),
    .owned     (owned),
    .rx_load   (rx_load),
    .eng_start (eng_start),
    .eng_write (eng_write),
    .eng_tx    (eng_tx_byte),
    .eng_cfg   (eng_cfg)
  );

  always_comb begin
    rdata_nxt = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (region == REG_W'(g)) rdata_nxt = bank_rdata[g];
    end
    if (arb_hit) rdata_nxt = {arb_en_q, {(DATA_W-1){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arb_en_q  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && arb_hit) arb_en_q <= reg_wdata[DATA_W-1];
      if (reg_rd) reg_rdata <= rdata_nxt;
    end
  end

  // R12: writes that hit no register leave the arbiter enable alone
  a_r12_arb_untouched: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && arb_hit) |=> $stable(arb_en_q));
endmodule

// File: tb/dspi_regfront_bench.sv
module dspi_regfront_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_word_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  spi_cs_n;
  logic        eng_start, eng_write;
  logic [7:0]  eng_tx_byte;
  logic [8:0]  eng_cfg;
  logic        eng_done;
  logic [7:0]  eng_rx_byte;

  always #5 clk = ~clk;

  dspi_regfront u_dspi_regfront (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_word_addr(reg_word_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_cs_n(spi_cs_n), .eng_start(eng_start), .eng_write(eng_write),
    .eng_tx_byte(eng_tx_byte), .eng_cfg(eng_cfg), .eng_done(eng_done),
    .eng_rx_byte(eng_rx_byte)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int eng_lat = 3;
  int cnt = 0;
  int start_n = 0;
  int overlap_n = 0;
  logic [7:0] rx_val = 8'h00;
  logic [8:0] log_cfg [0:7];
  logic       log_dir [0:7];
  logic [7:0] log_tx  [0:7];

  logic [8:0] m_cfg  [0:1];
  logic       m_cs   [0:1];
  logic [7:0] m_data [0:1];
  logic       m_arb;

  // engine model, driven away from the active edge
  initial begin
    eng_done = 1'b0;
    eng_rx_byte = 8'h00;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          eng_done = 1'b1;
          eng_rx_byte = rx_val;
        end
      end
      if (eng_start) begin
        if (cnt != 0) overlap_n++;
        log_cfg[start_n % 8] = eng_cfg;
        log_dir[start_n % 8] = eng_write;
        log_tx[start_n % 8]  = eng_tx_byte;
        start_n++;
        cnt = eng_lat;
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", start_n, 0);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_word_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_word_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle(input int g);
    logic [31:0] d = 32'h1;
    for (int i = 0; i < 200; i++) begin
      brd(g[0] ? 6'h10 : 6'h00, d);
      if (d[0] == 1'b0) break;
    end
    check("R3 busy drops", d, 32'h0);
  endtask

  function automatic logic [31:0] exp_read(input int w);
    int rg = w / 16;
    int of = w % 16;
    logic [31:0] r = 32'h0;
    if (rg < 2) begin
      case (of)
        4: r = {23'h0, m_cfg[rg]};
        5: r = {31'h0, m_cs[rg]};
        8: r = {24'h0, m_data[rg]};
        default: r = 32'h0;
      endcase
    end else if (w == 6'h3C) begin
      r = {m_arb, 31'h0};
    end
    return r;
  endfunction

  function automatic bit defined_word(input int w);
    int of = w % 16;
    if (w == 6'h3C) return 1'b1;
    if (w < 32 && (of == 0 || of == 4 || of == 5 || of == 8)) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    logic [31:0] d;
    int base_n;
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_word_addr = '0; reg_wdata = '0;
    for (int g = 0; g < 2; g++) begin
      m_cfg[g] = '0; m_cs[g] = 1'b1; m_data[g] = '0;
    end
    m_arb = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2: reset values over the whole map
    check("R2 cs pins", {30'h0, spi_cs_n}, 32'h3);
    for (int w = 0; w < 64; w++) begin
      brd(6'(w), d);
      check("R2 reset read", d, exp_read(w));
    end

    // R13: configuration width
    bwr(6'h04, 32'hFFFF_FFFF);
    brd(6'h04, d);
    check("R13 cfg width", d, 32'h1FF);
    bwr(6'h04, 32'h0000_0101); m_cfg[0] = 9'h101;
    bwr(6'h14, 32'h0000_00F2); m_cfg[1] = 9'h0F2;
    brd(6'h14, d);
    check("R13 cfg g1", d, 32'hF2);

    // R4: chip-select pins
    bwr(6'h05, 32'h0);
    check("R4 cs g0 low", {30'h0, spi_cs_n}, 32'h2);
    bwr(6'h15, 32'h0);
    check("R4 cs both low", {30'h0, spi_cs_n}, 32'h0);
    bwr(6'h05, 32'h1);
    check("R4 cs g0 high", {30'h0, spi_cs_n}, 32'h1);
    bwr(6'h15, 32'h1);
    check("R4 cs g1 high", {30'h0, spi_cs_n}, 32'h3);

    // R10: group 1 held while the arbiter is disabled
    bwr(6'h18, 32'h77); m_data[1] = 8'h77;
    bwr(6'h15, 32'h4);  m_cs[1] = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 no launch", 32'(start_n), 32'd0);
    brd(6'h10, d);
    check("R10 g1 pending busy", d, 32'h1);
    brd(6'h15, d);
    check("R7 pending visible", d, 32'h4);
    bwr(6'h3C, 32'h8000_0000); m_arb = 1'b1;
    brd(6'h3C, d);
    check("R1 arbiter enable", d, 32'h8000_0000);
    wait_idle(1);
    check("R10 launched", 32'(start_n), 32'd1);
    check("R5 tx byte", 32'(log_tx[0]), 32'h77);
    check("R5 dir", 32'(log_dir[0]), 32'h1);
    check("R5 cfg", 32'(log_cfg[0]), 32'hF2);
    brd(6'h15, d);
    check("R7 cleared", d, 32'h0);
    brd(6'h18, d);
    check("R5 data kept", d, 32'h77);

    // R5 / R3: write sweep over every byte value
    for (int b = 0; b < 256; b++) begin
      int g = b % 2;
      logic [5:0] bs = (g == 1) ? 6'h10 : 6'h00;
      bwr(bs + 6'h8, 32'(b));
      bwr(bs + 6'h5, 32'h4);
      m_data[g] = 8'(b); m_cs[g] = 1'b0;
      brd(bs, d);
      check("R3 busy after start", d, 32'h1);
      wait_idle(g);
      check("R5 sweep tx", 32'(log_tx[(start_n - 1) % 8]), 32'(b));
      check("R5 sweep cfg", 32'(log_cfg[(start_n - 1) % 8]), 32'(m_cfg[g]));
    end

    // R6: read sweep
    for (int b = 0; b < 256; b++) begin
      int g = b % 2;
      logic [5:0] bs = (g == 1) ? 6'h10 : 6'h00;
      rx_val = 8'(b) ^ 8'h5A;
      bwr(bs + 6'h5, 32'h2);
      wait_idle(g);
      brd(bs + 6'h8, d);
      check("R6 rx byte", d, {24'h0, rx_val});
      check("R6 dir", 32'(log_dir[(start_n - 1) % 8]), 32'h0);
      m_data[g] = rx_val;
    end
    bwr(6'h08, 32'hFFFF_FF33); m_data[0] = 8'h33;
    brd(6'h08, d);
    check("R6 upper bits dropped", d, 32'h33);

    // R7: both start bits together
    bwr(6'h05, 32'h6);
    wait_idle(0);
    check("R7 write wins", 32'(log_dir[(start_n - 1) % 8]), 32'h1);
    check("R7 write wins tx", 32'(log_tx[(start_n - 1) % 8]), 32'h33);

    // R8 / R9: both groups queued behind a long transfer
    eng_lat = 12;
    rx_val = 8'h3C;
    base_n = start_n;
    bwr(6'h15, 32'h4);
    repeat (3) @(negedge clk);
    bwr(6'h15, 32'h2);
    bwr(6'h05, 32'h4);
    check("R8 held while busy", 32'(start_n), 32'(base_n + 1));
    brd(6'h00, d);
    check("R8 g0 pending busy", d, 32'h1);
    for (int i = 0; i < 400; i++) begin
      if (start_n >= base_n + 3) break;
      @(negedge clk);
    end
    wait_idle(0);
    wait_idle(1);
    m_data[1] = 8'h3C;
    check("R8 all launched", 32'(start_n), 32'(base_n + 3));
    check("R9 first owner", 32'(log_cfg[base_n % 8]), 32'hF2);
    check("R9 group 0 next", 32'(log_cfg[(base_n + 1) % 8]), 32'h101);
    check("R9 group 1 last", 32'(log_cfg[(base_n + 2) % 8]), 32'hF2);
    check("R11 no overlap", 32'(overlap_n), 32'd0);
    eng_lat = 3;

    // R12: reserved words ignore writes and read zero
    base_n = start_n;
    for (int w = 0; w < 64; w++) begin
      if (!defined_word(w)) bwr(6'(w), 32'hFFFF_FFFF);
    end
    repeat (20) @(negedge clk);
    check("R12 pins", {30'h0, spi_cs_n}, {30'h0, m_cs[1], m_cs[0]});
    check("R12 no launch", 32'(start_n), 32'(base_n));
    for (int w = 0; w < 64; w++) begin
      brd(6'(w), d);
      check("R12 map read", d, exp_read(w));
    end

    summary();
  end
endmodule